// File: doc/BRIEF.md
# Counter Overflow Status Aggregator

This block holds the event-selector registers for hardware performance counters 3 through 31 and gives software a single read-only word that summarises their overflow state. Each selector keeps a sticky overflow flag and five inhibit bits, one for each privilege level: machine, supervisor, user, virtual-supervisor and virtual-user. A per-counter overflow pulse from the counter logic sets the matching flag. The flag then stays set until software writes it back to zero. Whenever any flag goes from clear to set, the block raises a one-cycle request toward the local counter-overflow interrupt pending bit.

Software reaches the block through a CSR-style port. A request is decoded in the same cycle and its read data is returned combinationally. A write takes effect at the next rising clock edge. The parameter `XLEN` chooses 64-bit access or split 32-bit access. In the 32-bit case each selector has a low half at its base address and a high half at a second address. The summary word reports each overflow flag only where the machine counter-enable bit for that counter is set. In virtualized mode the hypervisor counter-enable bit for that counter must also be set. The input `ext_en` turns the overflow feature on or off at run time.

Top module: `cntovf_agg`

## Requirements
- R1: After synchronous reset every selector reads zero, the summary reads zero and `lcof_req` is low.
- R2: Summary bits 0 to 2 read zero. For i in 3 to 31, summary bit i equals the overflow flag of selector i ANDed with `mcounteren[i]`. The summary sits at address 0xDA0, zero-extended to XLEN.
- R3: While `virt_mode` is high, each summary bit i is also ANDed with `hcounteren[i]`.
- R4: While `ext_en` is low, any access to the summary address raises `csr_illegal` in the same cycle with read data zero. A write to the summary never changes any state.
- R5: Selector i (64-bit view) sits at address 0x323+(i-3). Only bits 63:58 are stored: overflow at 63, machine inhibit at 62, supervisor at 61, user at 60, virtual-supervisor at 59 and virtual-user at 58. All other bits read zero.
- R6: While `ext_en` is low, selectors read zero. Writes and overflow pulses are ignored. Stored values come back when the feature is turned on again.
- R7: With XLEN=32, the low half at 0x323+(i-3) always reads zero and ignores writes. The high half at 0x723+(i-3) maps bits 63:32 of the selector, so bits 31:26 of the word hold the six fields. An access to the high half while `ext_en` is low raises `csr_illegal`.
- R8: `ovf_pulse[i-3]` sets the overflow flag of selector i. The flag is sticky. A pulse wins over a software clear in the same cycle.
- R9: `lcof_req` is high for exactly the one cycle in which at least one overflow flag first reads set after having been clear. A pulse on a flag that is already set gives no request.
- R10: An address outside the block's map returns zero and never raises `csr_illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_en | input | 1 | Overflow feature enable |
| virt_mode | input | 1 | Hart running virtualized |
| mcounteren | input | 32 | Machine counter-enable register value |
| hcounteren | input | 32 | Hypervisor counter-enable register value |
| ovf_pulse | input | 29 | Per-counter overflow pulse, bit 0 = counter 3 |
| csr_req | input | 1 | CSR access valid |
| csr_we | input | 1 | CSR access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data (combinational) |
| csr_illegal | output | 1 | Illegal-access indication |
| lcof_req | output | 1 | One-cycle overflow interrupt request |

## Verification
A corrupted field bit in a selector shows up at the very next read of that selector. A corrupted overflow flag also changes the summary word in the same cycle, provided its counter is enabled. A wrong flag transition shows on `lcof_req` one clock after the write or pulse that caused it. That is either a missing pulse or a spurious one. Wrong gating or decode is visible at once on `csr_rdata` or `csr_illegal` for the access that exposes it. Because of this, the bench runs directed corner cases and a seeded random mix of writes, pulses and reads against a reference model, and compares the outputs every cycle.

// File: rtl/cntovf_pkg.sv
package cntovf_pkg;

    // Field order matches bit order: ovf lands on bit 63, vu_inh on bit 58.
    typedef struct packed {
        logic ovf;
        logic m_inh;
        logic s_inh;
        logic u_inh;
        logic vs_inh;
        logic vu_inh;
    } sel_fields_t;

    localparam int FIELD_W   = $bits(sel_fields_t);
    localparam int FIELD_LSB = 64 - FIELD_W;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_SEL_LO,
        KIND_SEL_HI,
        KIND_SUM
    } csr_kind_t;

endpackage

// File: rtl/cntovf_decode.sv
module cntovf_decode
    import cntovf_pkg::*;
#(
    parameter int          XLEN        = 64,
    parameter int          NUM_SEL     = 29,
    parameter int          IDX_W       = 5,
    parameter logic [11:0] SEL_BASE    = 12'h323,
    parameter logic [11:0] SEL_HI_BASE = 12'h723,
    parameter logic [11:0] SUM_ADDR    = 12'hDA0
) (
    input  logic [11:0]      addr,
    output csr_kind_t        kind,
    output logic [IDX_W-1:0] idx
);
    localparam logic [11:0] NSEL12 = 12'(NUM_SEL);

    logic [11:0] off_lo;
    logic [11:0] off_hi;

    always_comb begin
        off_lo = addr - SEL_BASE;
        off_hi = addr - SEL_HI_BASE;
        kind   = KIND_NONE;
        idx    = '0;
        if (addr == SUM_ADDR) begin
            kind = KIND_SUM;
        end else if (off_lo < NSEL12) begin
            kind = KIND_SEL_LO;
            idx  = off_lo[IDX_W-1:0];
        end else if ((XLEN == 32) && (off_hi < NSEL12)) begin
            kind = KIND_SEL_HI;
            idx  = off_hi[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/cntovf_sel_bank.sv
module cntovf_sel_bank
    import cntovf_pkg::*;
#(
    parameter int NUM_SEL = 29,
    parameter int IDX_W   = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ext_en,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  sel_fields_t               wr_fields,
    input  logic [NUM_SEL-1:0]        pulse,
    output sel_fields_t [NUM_SEL-1:0] sel_q,
    output logic [NUM_SEL-1:0]        ovf_vec,
    output logic                      lcof_req
);
    logic [NUM_SEL-1:0] rise;

    for (genvar k = 0; k < NUM_SEL; k++) begin : g_sel
        logic        hit;
        sel_fields_t nxt;

        always_comb begin
            hit = wr_en && (wr_idx == IDX_W'(k));
            nxt = sel_q[k];
            if (hit)
                nxt = wr_fields;
            if (ext_en && pulse[k])
                nxt.ovf = 1'b1;   // pulse beats a same-cycle clear
            rise[k]    = nxt.ovf & ~sel_q[k].ovf;
            ovf_vec[k] = sel_q[k].ovf;
        end

        always_ff @(posedge clk) begin
            if (rst)
                sel_q[k] <= '0;
            else
                sel_q[k] <= nxt;
        end

        // R8: a pulse always leaves the flag set
        a_r8_pulse_sets: assert property (@(posedge clk) disable iff (rst)
            (ext_en && pulse[k]) |=> sel_q[k].ovf);
        // R8: without a write to this selector the flag stays set
        a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
            (sel_q[k].ovf && !(wr_en && wr_idx == IDX_W'(k))) |=> sel_q[k].ovf);
    end

    always_ff @(posedge clk) begin
        if (rst)
            lcof_req <= 1'b0;
        else
            lcof_req <= |rise;
    end

    // R9: a request only accompanies a flag that just became set
    a_r9_req_on_rise: assert property (@(posedge clk) disable iff (rst)
        lcof_req |-> (|(ovf_vec & ~$past(ovf_vec))));
endmodule

// File: rtl/cntovf_summary.sv
module cntovf_summary #(
    parameter int NUM_SEL   = 29,
    parameter int FIRST_IDX = 3,
    parameter int SUM_W     = FIRST_IDX + NUM_SEL
) (
    input  logic [NUM_SEL-1:0] flags,
    input  logic [SUM_W-1:0]   mce,
    input  logic [SUM_W-1:0]   hce,
    input  logic               virt,
    output logic [SUM_W-1:0]   summary
);
    for (genvar i = 0; i < SUM_W; i++) begin : g_bit
        if (i < FIRST_IDX) begin : g_zero
            assign summary[i] = 1'b0;
        end else begin : g_gate
            assign summary[i] = flags[i-FIRST_IDX] & mce[i] & (~virt | hce[i]);
        end
    end
endmodule

// File: rtl/cntovf_agg.sv
module cntovf_agg
    import cntovf_pkg::*;
#(
    parameter int          XLEN        = 64,
    parameter int          NUM_SEL     = 29,
    parameter int          FIRST_IDX   = 3,
    parameter logic [11:0] SEL_BASE    = 12'h323,
    parameter logic [11:0] SEL_HI_BASE = 12'h723,
    parameter logic [11:0] SUM_ADDR    = 12'hDA0,
    localparam int         CNT_W       = FIRST_IDX + NUM_SEL,
    localparam int         IDX_W       = $clog2(NUM_SEL)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ext_en,
    input  logic               virt_mode,
    input  logic [CNT_W-1:0]   mcounteren,
    input  logic [CNT_W-1:0]   hcounteren,
    input  logic [NUM_SEL-1:0] ovf_pulse,
    input  logic               csr_req,
    input  logic               csr_we,
    input  logic [11:0]        csr_addr,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    output logic               csr_illegal,
    output logic               lcof_req
);
    csr_kind_t                 kind;
    logic [IDX_W-1:0]          idx;
    sel_fields_t [NUM_SEL-1:0] sel_q;
    logic [NUM_SEL-1:0]        ovf_vec;
    logic [CNT_W-1:0]          summary;
    logic                      wr_en;
    sel_fields_t               wr_fields;
    logic [63:0]               wd64;
    logic [63:0]               full;
    logic [63:0]               rd64;

    cntovf_decode #(
        .XLEN(XLEN), .NUM_SEL(NUM_SEL), .IDX_W(IDX_W),
        .SEL_BASE(SEL_BASE), .SEL_HI_BASE(SEL_HI_BASE), .SUM_ADDR(SUM_ADDR)
    ) u_dec (
        .addr(csr_addr), .kind(kind), .idx(idx)
    );

    always_comb begin
        wd64            = '0;
        wd64[XLEN-1:0]  = csr_wdata;
        wr_fields       = (kind == KIND_SEL_HI) ? sel_fields_t'(wd64[31:32-FIELD_W])
                                                : sel_fields_t'(wd64[63:FIELD_LSB]);
        wr_en           = csr_req && csr_we && ext_en &&
                          (((kind == KIND_SEL_LO) && (XLEN == 64)) || (kind == KIND_SEL_HI));
    end

    cntovf_sel_bank #(.NUM_SEL(NUM_SEL), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst(rst), .ext_en(ext_en),
        .wr_en(wr_en), .wr_idx(idx), .wr_fields(wr_fields),
        .pulse(ovf_pulse), .sel_q(sel_q), .ovf_vec(ovf_vec), .lcof_req(lcof_req)
    );

    cntovf_summary #(.NUM_SEL(NUM_SEL), .FIRST_IDX(FIRST_IDX)) u_sum (
        .flags(ovf_vec), .mce(mcounteren), .hce(hcounteren),
        .virt(virt_mode), .summary(summary)
    );

    always_comb begin
        full = {sel_q[idx], {FIELD_LSB{1'b0}}};
        rd64 = '0;
        unique case (kind)
            KIND_SEL_LO: rd64 = full;
            KIND_SEL_HI: rd64 = {32'b0, full[63:32]};
            KIND_SUM:    rd64[CNT_W-1:0] = summary;
            default:     rd64 = '0;
        endcase
        if (!ext_en)
            rd64 = '0;
        csr_rdata   = rd64[XLEN-1:0];
        csr_illegal = csr_req && !ext_en &&
                      ((kind == KIND_SUM) || (kind == KIND_SEL_HI));
    end

    // R2: the lowest summary bits never report anything
    a_r2_low_zero: assert property (@(posedge clk) disable iff (rst)
        summary[FIRST_IDX-1:0] == '0);
    // R2: a summary bit requires its machine enable
    a_r2_mce_gate: assert property (@(posedge clk) disable iff (rst)
        (summary & ~mcounteren) == '0);
    // R3: when virtualized a summary bit also requires its hypervisor enable
    a_r3_hce_gate: assert property (@(posedge clk) disable iff (rst)
        virt_mode |-> ((summary & ~hcounteren) == '0));
    // R4: no illegal indication without a request
    a_r4_idle_legal: assert property (@(posedge clk) disable iff (rst)
        !csr_req |-> !csr_illegal);
    // R6: the enable gates the read data
    a_r6_off_zero: assert property (@(posedge clk) disable iff (rst)
        !ext_en |-> (csr_rdata == '0));
endmodule

// File: tb/sim_cntovf_agg.sv
`timescale 1ns/1ps
module sim_cntovf_agg;
    localparam logic [11:0] A_SEL = 12'h323;
    localparam logic [11:0] A_HI  = 12'h723;
    localparam logic [11:0] A_SUM = 12'hDA0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_en = 1'b0;
    logic        virt = 1'b0;
    logic [31:0] mce = '0;
    logic [31:0] hce = '0;
    logic [28:0] pulse = '0;
    logic        req0 = 1'b0;
    logic        req1 = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata0;
    logic [31:0] rdata1;
    logic        ill0, ill1, lreq0, lreq1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [5:0] m64 [29];
    logic [5:0] m32 [29];

    always #10 clk = ~clk;

    cntovf_agg #(.XLEN(64)) u0 (
        .clk(clk), .rst(rst), .ext_en(ext_en), .virt_mode(virt),
        .mcounteren(mce), .hcounteren(hce), .ovf_pulse(pulse),
        .csr_req(req0), .csr_we(we), .csr_addr(addr), .csr_wdata(wdata),
        .csr_rdata(rdata0), .csr_illegal(ill0), .lcof_req(lreq0)
    );

    cntovf_agg #(.XLEN(32)) u1 (
        .clk(clk), .rst(rst), .ext_en(ext_en), .virt_mode(virt),
        .mcounteren(mce), .hcounteren(hce), .ovf_pulse(pulse),
        .csr_req(req1), .csr_we(we), .csr_addr(addr), .csr_wdata(wdata[31:0]),
        .csr_rdata(rdata1), .csr_illegal(ill1), .lcof_req(lreq1)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] summ(input logic [28:0] f);
        logic [31:0] s = '0;
        for (int i = 3; i < 32; i++)
            s[i] = f[i-3] & mce[i] & (~virt | hce[i]);
        return s;
    endfunction

    function automatic logic [28:0] flags64();
        logic [28:0] f;
        for (int k = 0; k < 29; k++) f[k] = m64[k][5];
        return f;
    endfunction

    function automatic logic [28:0] flags32();
        logic [28:0] f;
        for (int k = 0; k < 29; k++) f[k] = m32[k][5];
        return f;
    endfunction

    function automatic logic [63:0] exp_rd64(input logic [11:0] a);
        logic [11:0] o = a - A_SEL;
        if (!ext_en) return '0;
        if (a == A_SUM) return {32'b0, summ(flags64())};
        if (o < 12'd29) return {m64[o], 58'b0};
        return '0;
    endfunction

    function automatic logic [31:0] exp_rd32(input logic [11:0] a);
        logic [11:0] oh = a - A_HI;
        if (!ext_en) return '0;
        if (a == A_SUM) return summ(flags32());
        if (oh < 12'd29) return {m32[oh], 26'b0};
        return '0;
    endfunction

    function automatic logic exp_ill(input logic [11:0] a, input bit is32);
        logic [11:0] oh = a - A_HI;
        if (ext_en) return 1'b0;
        if (a == A_SUM) return 1'b1;
        if (is32 && oh < 12'd29) return 1'b1;
        return 1'b0;
    endfunction

    // One clock of stimulus: read checks before the edge, request check after it.
    task automatic step(input logic [28:0] pv, input logic r0, input logic r1,
                        input logic w, input logic [11:0] a, input logic [63:0] d,
                        input string tag);
        logic [28:0] o64, o32;
        pulse = pv; req0 = r0; req1 = r1; we = w; addr = a; wdata = d;
        #1;
        if (r0) begin
            chk({tag, " ill64"}, 64'(ill0), 64'(exp_ill(a, 1'b0)));
            if (!w) chk({tag, " rd64"}, rdata0, exp_rd64(a));
        end
        if (r1) begin
            chk({tag, " ill32"}, 64'(ill1), 64'(exp_ill(a, 1'b1)));
            if (!w) chk({tag, " rd32"}, 64'(rdata1), 64'(exp_rd32(a)));
        end
        o64 = flags64();
        o32 = flags32();
        for (int k = 0; k < 29; k++) begin
            if (ext_en) begin
                if (r0 && w && a == A_SEL + 12'(k)) m64[k] = d[63:58];
                if (r1 && w && a == A_HI + 12'(k))  m32[k] = d[31:26];
                if (pv[k]) begin
                    m64[k][5] = 1'b1;
                    m32[k][5] = 1'b1;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R9 req64"}, 64'(lreq0), 64'(|(flags64() & ~o64)));
        chk({tag, " R9 req32"}, 64'(lreq1), 64'(|(flags32() & ~o32)));
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        step('0, 1'b1, 1'b1, 1'b0, a, '0, tag);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 29; k++) begin m64[k] = '0; m32[k] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ext_en = 1'b1;
        mce = '1;
        hce = '1;
        // R1 reset state
        rd(A_SUM, "R1 summary");
        rd(A_SEL + 12'd7, "R1 selector");
        chk("R1 req", 64'(lreq0 | lreq1), 64'd0);

        // R5 only fields 63:58 are stored; setting ovf raises request (R9)
        step('0, 1'b1, 1'b0, 1'b1, A_SEL + 12'd2, '1, "R5 write all ones");
        rd(A_SEL + 12'd2, "R5 readback");
        // R2 summary bit 5 and masking by machine enable
        rd(A_SUM, "R2 summary bit5");
        mce = ~32'h20;
        rd(A_SUM, "R2 masked by mce");
        mce = '1;
        // R3 hypervisor gating while virtualized
        virt = 1'b1; hce = '0;
        rd(A_SUM, "R3 hce zero");
        hce = 32'h20;
        rd(A_SUM, "R3 hce bit5");
        virt = 1'b0; hce = '1;

        // R8 pulse sets, sticky, beats same-cycle clear
        step(29'(1) << 7, 1'b0, 1'b0, 1'b0, '0, '0, "R8 pulse");
        rd(A_SEL + 12'd7, "R8 flag set");
        step(29'(1) << 7, 1'b0, 1'b0, 1'b0, '0, '0, "R9 pulse on set flag");
        step(29'(1) << 7, 1'b1, 1'b0, 1'b1, A_SEL + 12'd7, '0, "R8 pulse vs clear");
        rd(A_SEL + 12'd7, "R8 pulse wins");
        step('0, 1'b1, 1'b0, 1'b1, A_SEL + 12'd7, '0, "R8 sw clear");
        rd(A_SEL + 12'd7, "R8 cleared");

        // R7 split halves
        step('0, 1'b0, 1'b1, 1'b1, A_HI + 12'd4, 64'hFFFF_FFFF, "R7 hi write");
        rd(A_HI + 12'd4, "R7 hi read");
        step('0, 1'b0, 1'b1, 1'b1, A_SEL + 12'd4, 64'h0, "R7 lo write ignored");
        rd(A_SEL + 12'd4, "R7 lo reads zero");
        rd(A_HI + 12'd4, "R7 hi kept");

        // R10 unmapped address
        rd(12'h100, "R10 unmapped");

        // R4 / R6 / R7 feature disabled
        ext_en = 1'b0;
        rd(A_SUM, "R4 summary illegal");
        step('0, 1'b1, 1'b1, 1'b1, A_SUM, '1, "R4 summary write");
        rd(A_HI + 12'd4, "R7 hi illegal off");
        step('1, 1'b1, 1'b0, 1'b1, A_SEL + 12'd2, '0, "R6 write+pulse ignored");
        rd(A_SEL + 12'd2, "R6 reads zero");
        ext_en = 1'b1;
        rd(A_SEL + 12'd2, "R6 value kept");
        rd(A_SUM, "R4 summary unchanged");

        // random mix
        for (int n = 0; n < 600; n++) begin
            int unsigned k = $urandom % 29;
            int unsigned sel = $urandom % 4;
            logic [11:0] a;
            logic [28:0] pv;
            if (n % 20 == 0) begin
                mce = $urandom; hce = $urandom; virt = 1'($urandom);
                ext_en = ($urandom % 8) != 0;
            end
            case (sel)
                0: a = A_SEL + 12'(k);
                1: a = A_HI + 12'(k);
                2: a = A_SUM;
                default: a = 12'($urandom);
            endcase
            pv = ($urandom % 3 == 0) ? (29'(1) << ($urandom % 29)) : '0;
            step(pv, 1'($urandom), 1'($urandom), 1'(($urandom % 3) == 0), a,
                 {$urandom, $urandom}, "R5 random");
        end
        step('0, 1'b0, 1'b0, 1'b0, '0, '0, "R9 idle");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule